// File: doc/BRIEF.md
# Configurable-Width SPI Frame Shifter

This block moves one serial frame between a parallel word interface and a four-wire serial link. Each frame carries 4 to 16 bits, selected by a 4-bit width code. Bits go out most significant first. The block works either as the clock-owning master or as a slave that follows an external clock and chip select. Clock polarity and clock phase are both selectable. The transmit word enters through a valid/ready handshake. The received word leaves through a second valid/ready handshake, right-justified and with its upper bits cleared.

In master role the block makes the serial clock from the system clock with a fixed half-period divider. It drives chip select low for exactly one frame. In slave role it passes the external clock and chip select through a short synchronizer and reacts to their edges. A word may be preloaded before the external master starts a frame. If no word is preloaded, the slave sends zeros. An internal loopback connects the transmit shift path to the receive shift path. A slave-side output-disable lets several slaves listen to one broadcast while none of them drives the shared data line. A busy flag shows that a frame is in flight or that transmit data is still waiting.

Top module: `spi_frame_shifter`

## Requirements
- R1: Width code n (3..15) gives frames of n+1 bits: in master role exactly n+1 leading serial-clock edges occur while chip select is low. The code is latched at frame start. Codes 0 to 2 behave as code 3.
- R2: The transmit word is right-justified. Bit n is sent first, bit 0 is sent last, and bits above n have no effect on the line.
- R3: A received word is delivered right-justified, with the first received bit at position n and every bit above n equal to 0.
- R4: The serial clock idles at the polarity setting. With phase 0, data is presented before the first edge and sampled on odd edges. With phase 1, data is presented on odd edges and sampled on even edges.
- R5: With loopback set, the received word equals the masked transmit word, and the serial data input has no effect.
- R6: In slave role with output-disable set, the data output enable stays 0 at all times.
- R7: The role input is taken only while the enable input is 0. Changing it while enabled leaves the active role unchanged.
- R8: Busy is 1 while a frame is in progress and while a preloaded transmit word is waiting. It is 0 when idle with nothing pending.
- R9: In master role, chip select is low from frame start until after the last clock edge, and high between frames.
- R10: In slave role the block shifts on the externally supplied clock while chip select is low. It sends the preloaded word, or all zeros when none was preloaded.
- R11: The received word and its valid flag hold unchanged until the receiver accepts the word with ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; 0 aborts any frame |
| slave_sel | input | 1 | Requested role (1 = slave), taken only while en is 0 |
| size_code | input | 4 | Frame width code, frame length = code + 1 bits |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase selection |
| loopback | input | 1 | Feed the transmit shift output into the receive shift input |
| slave_tx_off | input | 1 | Never drive data output in slave role |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted this cycle when tx_valid is also 1 |
| tx_data | input | 16 | Right-justified transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word consumed |
| rx_data | output | 16 | Right-justified received word |
| sck_o | output | 1 | Serial clock output (master role) |
| csn_o | output | 1 | Active-low chip select output (master role) |
| sck_i | input | 1 | Serial clock input (slave role) |
| csn_i | input | 1 | Active-low chip select input (slave role) |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data input |
| busy | output | 1 | Frame in flight or transmit word pending |

## Verification
The hardest case to reach is slave role. There the timing belongs to an outside agent, and the block sees that agent's clock and chip select only after a synchronizer delay. The bench therefore acts as the external master itself. It toggles sck_i and csn_i with a slow half period and changes sdi only on the edges where data is launched. It reads sdo on the opposite edges, and does this for every mix of polarity, phase, preload and output-disable. Master role is covered by a bench-side slave model and by loopback frames with random widths and words.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned SIZE_W   = 4;
    localparam int unsigned CNT_W    = SIZE_W + 1;
    localparam int unsigned EDGE_W   = SIZE_W + 2;
    localparam logic [SIZE_W-1:0] SIZE_MIN = 4'd3;
    localparam logic [SIZE_W-1:0] SIZE_TOP = 4'd15;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_e;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_SHIFT = 2'd1,
        MS_TAIL  = 2'd2
    } mstate_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic loop;
    } frame_cfg_t;

    // Reserved short codes are treated as the smallest legal width.
    function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] code);
        return (code < SIZE_MIN) ? SIZE_MIN : code;
    endfunction

    // Ones in the bit positions that belong to a frame of code sz.
    function automatic word_t keep_mask(input logic [SIZE_W-1:0] sz);
        word_t ones;
        ones = '1;
        return ones >> (SIZE_TOP - sz);
    endfunction

    // Moves the frame's top bit into the word's MSB position.
    function automatic word_t align_msb(input word_t w, input logic [SIZE_W-1:0] sz);
        return w << (SIZE_TOP - sz);
    endfunction

endpackage

// File: rtl/spi_fs_shifter.sv
module spi_fs_shifter
    import spi_fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start,
    input  logic [SIZE_W-1:0] size,
    input  logic              cpha,
    input  word_t             word,
    input  logic              launch,
    input  logic              sample,
    input  logic              din,
    output logic              dout,
    output word_t             rx_word,
    output logic              rx_done
);

    word_t             tx_sh;
    word_t             rx_sh;
    word_t             rx_nx;
    word_t             aligned;
    logic [CNT_W-1:0]  cnt;
    logic [SIZE_W-1:0] nb;
    logic              full;

    assign aligned = align_msb(word, size);
    assign rx_nx   = {rx_sh[WORD_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
            rx_done <= 1'b0;
            dout    <= 1'b0;
            cnt     <= '0;
            nb      <= SIZE_MIN;
            full    <= 1'b1;
        end else begin
            rx_done <= 1'b0;
            if (abort) begin
                full <= 1'b1;
                cnt  <= '0;
            end else if (start) begin
                nb    <= size;
                rx_sh <= '0;
                cnt   <= '0;
                full  <= 1'b0;
                if (!cpha) begin
                    dout  <= aligned[WORD_W-1];
                    tx_sh <= aligned << 1;
                end else begin
                    dout  <= 1'b0;
                    tx_sh <= aligned;
                end
            end else begin
                if (launch && !full) begin
                    dout  <= tx_sh[WORD_W-1];
                    tx_sh <= tx_sh << 1;
                end
                if (sample && !full) begin
                    rx_sh <= rx_nx;
                    cnt   <= cnt + 1'b1;
                    if (cnt[SIZE_W-1:0] == nb) begin
                        full    <= 1'b1;
                        rx_done <= 1'b1;
                        rx_word <= rx_nx;
                    end
                end
            end
        end
    end

    // R1: never more samples than the latched frame width
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        !full |-> (cnt <= {1'b0, nb}));

    // R3: a finished word has nothing above the frame's top bit
    assert_rx_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> ((rx_word & ~keep_mask(nb)) == '0));

endmodule

// File: rtl/spi_fs_master_clk.sv
module spi_fs_master_clk
    import spi_fs_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [SIZE_W-1:0] size,
    output logic              sck,
    output logic              csn,
    output logic              launch,
    output logic              sample,
    output logic              active
);

    localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    mstate_e           state;
    logic [DIV_W-1:0]  div;
    logic [EDGE_W-1:0] edge_n;
    logic [EDGE_W-1:0] edge_nx;
    logic [EDGE_W-1:0] total;
    logic [SIZE_W-1:0] size_q;
    logic              cpol_q;
    logic              cpha_q;
    logic              level;
    logic              odd;

    assign edge_nx = edge_n + 1'b1;
    assign odd     = edge_nx[0];
    assign total   = ({2'b00, size_q} + 1'b1) << 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= MS_IDLE;
            div    <= '0;
            edge_n <= '0;
            size_q <= SIZE_MIN;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            level  <= 1'b0;
            launch <= 1'b0;
            sample <= 1'b0;
        end else begin
            launch <= 1'b0;
            sample <= 1'b0;
            if (abort) begin
                state <= MS_IDLE;
                level <= 1'b0;
                div   <= '0;
            end else begin
                case (state)
                    MS_IDLE: begin
                        if (start) begin
                            state  <= MS_SHIFT;
                            div    <= '0;
                            edge_n <= '0;
                            level  <= 1'b0;
                            size_q <= size;
                            cpol_q <= cpol;
                            cpha_q <= cpha;
                        end
                    end
                    MS_SHIFT: begin
                        if (div == DIV_LAST) begin
                            div    <= '0;
                            level  <= ~level;
                            edge_n <= edge_nx;
                            sample <= cpha_q ? !odd : odd;
                            launch <= cpha_q ? odd : (!odd && (edge_nx != total));
                            if (edge_nx == total) state <= MS_TAIL;
                        end else begin
                            div <= div + 1'b1;
                        end
                    end
                    MS_TAIL: begin
                        if (div == DIV_LAST) begin
                            div   <= '0;
                            state <= MS_IDLE;
                        end else begin
                            div <= div + 1'b1;
                        end
                    end
                    default: state <= MS_IDLE;
                endcase
            end
        end
    end

    assign active = (state != MS_IDLE);
    assign csn    = (state == MS_IDLE);
    assign sck    = (state == MS_IDLE) ? cpol : (cpol_q ^ level);

    // R9: every launch or sample happens with chip select low
    assert_csn_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (launch || sample) |-> !csn);

    // R4: the clock is back at its idle level whenever the frame ends
    assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
        (state == MS_TAIL) |-> (level == 1'b0));

endmodule

// File: rtl/spi_fs_slave_sync.sv
module spi_fs_slave_sync
    import spi_fs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic csn_i,
    input  logic cpol,
    output logic cs_fall,
    output logic cs_high,
    output logic lead,
    output logic trail
);

    localparam int unsigned LAST = SYNC_STAGES;

    logic [LAST:0] sck_p;
    logic [LAST:0] csn_p;
    logic          sck_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            csn_p <= '1;
        end else begin
            sck_p[0] <= sck_i;
            csn_p[0] <= csn_i;
            for (int i = 1; i <= int'(LAST); i++) begin
                sck_p[i] <= sck_p[i-1];
                csn_p[i] <= csn_p[i-1];
            end
        end
    end

    assign sck_edge = sck_p[LAST-1] ^ sck_p[LAST];
    assign cs_fall  = csn_p[LAST] & ~csn_p[LAST-1];
    assign cs_high  = csn_p[LAST-1];
    assign lead     = sck_edge & ~cs_high & (sck_p[LAST-1] != cpol);
    assign trail    = sck_edge & ~cs_high & (sck_p[LAST-1] == cpol);

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_fs_pkg::*;
#(
    parameter int unsigned HALF_DIV    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        slave_sel,
    input  logic [3:0]  size_code,
    input  logic        cpol,
    input  logic        cpha,
    input  logic        loopback,
    input  logic        slave_tx_off,
    input  logic        tx_valid,
    output logic        tx_ready,
    input  logic [15:0] tx_data,
    output logic        rx_valid,
    input  logic        rx_ready,
    output logic [15:0] rx_data,
    output logic        sck_o,
    output logic        csn_o,
    input  logic        sck_i,
    input  logic        csn_i,
    output logic        sdo,
    output logic        sdo_oe,
    input  logic        sdi,
    output logic        busy
);

    role_e             role_q;
    logic              is_slave;
    logic [SIZE_W-1:0] sz;
    frame_cfg_t        cfg_q;

    logic  m_start, m_launch, m_sample, m_active;
    logic  s_cs_fall, s_cs_high, s_lead, s_trail;
    logic  s_start, s_active, s_accept;
    logic  tx_loaded;
    word_t tx_buf;
    word_t start_word;
    logic  sh_start, sh_launch, sh_sample, sh_din, sh_dout, sh_done;
    word_t sh_word;
    logic  rx_valid_q;
    word_t rx_data_q;

    assign is_slave = (role_q == ROLE_SLAVE);
    assign sz       = clamp_size(size_code);

    // Role is captured only while the port is disabled.
    always_ff @(posedge clk) begin
        if (rst)      role_q <= ROLE_MASTER;
        else if (!en) role_q <= slave_sel ? ROLE_SLAVE : ROLE_MASTER;
    end

    // Parallel transmit side
    assign tx_ready = en && (is_slave ? (!tx_loaded && !s_active) : !m_active);
    assign m_start  = tx_valid && tx_ready && !is_slave;
    assign s_accept = tx_valid && tx_ready && is_slave;
    assign s_start  = en && is_slave && !s_active && s_cs_fall;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tx_loaded <= 1'b0;
            tx_buf    <= '0;
            s_active  <= 1'b0;
        end else begin
            if (s_start) begin
                tx_loaded <= 1'b0;
            end else if (s_accept) begin
                tx_loaded <= 1'b1;
                tx_buf    <= tx_data;
            end
            if (s_start)        s_active <= 1'b1;
            else if (s_cs_high) s_active <= 1'b0;
        end
    end

    always_comb begin
        if (!is_slave)      start_word = tx_data;
        else if (tx_loaded) start_word = tx_buf;
        else if (s_accept)  start_word = tx_data;
        else                start_word = '0;
    end

    assign sh_start = m_start | s_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (sh_start) begin
            cfg_q.cpol <= cpol;
            cfg_q.cpha <= cpha;
            cfg_q.loop <= loopback;
        end
    end

    spi_fs_master_clk #(.HALF_DIV(HALF_DIV)) u_mclk (
        .clk    (clk),
        .rst    (rst),
        .abort  (!en),
        .start  (m_start),
        .cpol   (cpol),
        .cpha   (cpha),
        .size   (sz),
        .sck    (sck_o),
        .csn    (csn_o),
        .launch (m_launch),
        .sample (m_sample),
        .active (m_active)
    );

    spi_fs_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ssync (
        .clk     (clk),
        .rst     (rst),
        .sck_i   (sck_i),
        .csn_i   (csn_i),
        .cpol    (cfg_q.cpol),
        .cs_fall (s_cs_fall),
        .cs_high (s_cs_high),
        .lead    (s_lead),
        .trail   (s_trail)
    );

    assign sh_launch = is_slave ? (s_active && (cfg_q.cpha ? s_lead : s_trail)) : m_launch;
    assign sh_sample = is_slave ? (s_active && (cfg_q.cpha ? s_trail : s_lead)) : m_sample;
    assign sh_din    = cfg_q.loop ? sh_dout : sdi;

    spi_fs_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .abort   (!en),
        .start   (sh_start),
        .size    (sz),
        .cpha    (cpha),
        .word    (start_word),
        .launch  (sh_launch),
        .sample  (sh_sample),
        .din     (sh_din),
        .dout    (sh_dout),
        .rx_word (sh_word),
        .rx_done (sh_done)
    );

    // Parallel receive side: hold until consumed
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else if (sh_done) begin
            rx_valid_q <= 1'b1;
            rx_data_q  <= sh_word;
        end else if (rx_ready) begin
            rx_valid_q <= 1'b0;
        end
    end

    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;
    assign sdo      = sh_dout;
    assign sdo_oe   = en && (!is_slave || (s_active && !slave_tx_off));
    assign busy     = m_active | s_active | tx_loaded;

    // R7: role is frozen across consecutive enabled cycles
    assert_role_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> (role_q == $past(role_q)));

    // R6: output-disabled slave never drives the data line
    assert_slave_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (is_slave && slave_tx_off) |-> !sdo_oe);

    // R8: an open master frame always reports busy
    assert_busy_frame_R8: assert property (@(posedge clk) disable iff (rst)
        !csn_o |-> busy);

    // R11: an unconsumed word stays put
    assert_rx_hold_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_valid_q) && !$past(rx_ready) && !$past(sh_done)) |->
        (rx_valid_q && $stable(rx_data_q)));

endmodule

// File: tb/tb_spi_frame_shifter.sv
module tb_spi_frame_shifter;

    logic        clk = 1'b0;
    logic        rst, en, slave_sel, cpol, cpha, loopback, slave_tx_off;
    logic [3:0]  size_code;
    logic        tx_valid, tx_ready, rx_valid, rx_ready;
    logic [15:0] tx_data, rx_data;
    logic        sck_o, csn_o, sck_i, csn_i, sdo, sdo_oe, sdi, busy;

    int n_chk = 0;
    int n_err = 0;
    bit oe_hit;
    localparam int H = 8;

    always #10 clk = ~clk;

    spi_frame_shifter dut (
        .clk(clk), .rst(rst), .en(en), .slave_sel(slave_sel), .size_code(size_code),
        .cpol(cpol), .cpha(cpha), .loopback(loopback), .slave_tx_off(slave_tx_off),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .sck_o(sck_o), .csn_o(csn_o), .sck_i(sck_i), .csn_i(csn_i),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .busy(busy)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fmask(input int sz);
        return 16'((32'd1 << (sz + 1)) - 1);
    endfunction

    task automatic tick();
        @(negedge clk);
        if (sdo_oe) oe_hit = 1'b1;
    endtask

    task automatic set_cfg(input bit slv, input int sz, input bit pol, input bit pha,
                           input bit lb, input bit off);
        en = 1'b0;
        tick();
        slave_sel = slv; size_code = 4'(sz); cpol = pol; cpha = pha;
        loopback = lb; slave_tx_off = off;
        sck_i = pol; csn_i = 1'b1;
        tick(); tick();
        en = 1'b1;
        tick();
    endtask

    task automatic send_tx(input logic [15:0] w);
        tx_data = w; tx_valid = 1'b1;
        while (!tx_ready) tick();
        tick();
        tx_valid = 1'b0;
    endtask

    task automatic get_rx(output logic [15:0] w);
        while (!rx_valid) tick();
        w = rx_data;
        rx_ready = 1'b1;
        tick();
        rx_ready = 1'b0;
    endtask

    task automatic m_loop(input int sz, input bit pol, input bit pha, input logic [15:0] txw);
        logic [15:0] r;
        set_cfg(1'b0, sz, pol, pha, 1'b1, 1'b0);
        sdi = ~txw[0];
        send_tx(txw);
        get_rx(r);
        check(r == (txw & fmask(sz)), "R5", "loopback word", r, txw & fmask(sz));
        check((r & ~fmask(sz)) == 16'h0, "R3", "upper bits zero", r, 0);
    endtask

    task automatic slave_model(input int sz, input bit pol, input bit pha, input logic [15:0] slw,
                               output logic [15:0] cap, output int leads, output bit idle_busy);
        bit prev;
        int e, bi;
        cap = '0; leads = 0; idle_busy = 1'b0;
        while (csn_o) tick();
        prev = pol; e = 0; bi = sz;
        if (!pha) begin sdi = slw[bi]; bi--; end
        while (!csn_o) begin
            if (!busy) idle_busy = 1'b1;
            if (sck_o != prev) begin
                prev = sck_o; e++;
                if (sck_o != pol) leads++;
                if ((pha && (e % 2 == 0)) || (!pha && (e % 2 == 1)))
                    cap = {cap[14:0], sdo};
                else if (bi >= 0) begin
                    sdi = slw[bi]; bi--;
                end
            end
            tick();
        end
    endtask

    task automatic m_ext(input int sz, input bit pol, input bit pha,
                         input logic [15:0] txw, input logic [15:0] slw);
        logic [15:0] cap, r;
        int leads;
        bit nb;
        set_cfg(1'b0, sz, pol, pha, 1'b0, 1'b0);
        check(sck_o == pol, "R4", "idle clock level", sck_o, pol);
        check(csn_o == 1'b1, "R9", "chip select idle high", csn_o, 1);
        fork
            send_tx(txw);
            slave_model(sz, pol, pha, slw, cap, leads, nb);
        join
        get_rx(r);
        check(leads == sz + 1, "R1", "leading edges per frame", leads, sz + 1);
        check(cap == (txw & fmask(sz)), "R2", "bits on line MSB first", cap, txw & fmask(sz));
        check(r == (slw & fmask(sz)), "R3", "received word", r, slw & fmask(sz));
        check(!nb, "R8", "busy through frame", nb, 0);
        check(csn_o == 1'b1, "R9", "chip select high after frame", csn_o, 1);
        check(sck_o == pol, "R4", "clock back at idle", sck_o, pol);
    endtask

    task automatic s_frame(input int sz, input bit pol, input bit pha, input bit pre,
                           input logic [15:0] txw, input logic [15:0] mw, input bit off);
        logic [15:0] cap, r, exp;
        cap = '0;
        set_cfg(1'b1, sz, pol, pha, 1'b0, off);
        oe_hit = 1'b0;
        if (pre) begin
            send_tx(txw);
            tick();
            check(busy == 1'b1, "R8", "busy with preloaded word", busy, 1);
        end else begin
            check(busy == 1'b0, "R8", "idle not busy", busy, 0);
        end
        if (!pha) sdi = mw[sz];
        csn_i = 1'b0;
        repeat (H) tick();
        for (int i = sz; i >= 0; i--) begin
            sck_i = ~pol;
            if (pha) sdi = mw[i];
            else     cap = {cap[14:0], sdo};
            repeat (H) tick();
            sck_i = pol;
            if (pha) cap = {cap[14:0], sdo};
            else if (i > 0) sdi = mw[i-1];
            repeat (H) tick();
        end
        csn_i = 1'b1;
        repeat (6) tick();
        get_rx(r);
        check(r == (mw & fmask(sz)), "R10", "slave received word", r, mw & fmask(sz));
        if (off) begin
            check(!oe_hit, "R6", "output enable in disabled slave", oe_hit, 0);
        end else begin
            exp = pre ? (txw & fmask(sz)) : 16'h0;
            check(cap == exp, "R10", "slave sent word", cap, exp);
            check(oe_hit, "R6", "slave drives when allowed", oe_hit, 1);
        end
        check(busy == 1'b0, "R8", "busy clear after slave frame", busy, 0);
    endtask

    initial begin
        logic [15:0] r, held;
        bit saw_cs;
        void'($urandom(32'd20240611));
        rst = 1'b1; en = 1'b0; slave_sel = 1'b0; size_code = 4'd7; cpol = 1'b0; cpha = 1'b0;
        loopback = 1'b0; slave_tx_off = 1'b0; tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b0;
        sck_i = 1'b0; csn_i = 1'b1; sdi = 1'b0; oe_hit = 1'b0;
        repeat (5) tick();
        rst = 1'b0;
        tick();
        check(tx_ready == 1'b0, "R7", "tx_ready while disabled", tx_ready, 0);
        check(rx_valid == 1'b0, "R11", "rx_valid after reset", rx_valid, 0);
        check(busy == 1'b0, "R8", "busy after reset", busy, 0);
        check(csn_o == 1'b1, "R9", "chip select after reset", csn_o, 1);
        check(sdo_oe == 1'b0, "R6", "output enable after reset", sdo_oe, 0);
        check(sck_o == 1'b0, "R4", "clock after reset", sck_o, 0);

        // Directed corners: extreme widths, all four clock modes
        for (int m = 0; m < 4; m++) begin
            m_ext(3, m[1], m[0], 16'hFFF5, 16'hABCA);
            m_ext(15, m[1], m[0], 16'h8001, 16'h7FFE);
        end
        m_loop(3, 1'b0, 1'b0, 16'hFFF0);
        m_loop(15, 1'b1, 1'b1, 16'hA5C3);

        // R11: hold the received word while not accepted
        set_cfg(1'b0, 7, 1'b0, 1'b1, 1'b1, 1'b0);
        send_tx(16'h12C6);
        while (!rx_valid) tick();
        held = rx_data;
        repeat (20) tick();
        check(rx_valid == 1'b1, "R11", "valid held", rx_valid, 1);
        check(rx_data == held, "R11", "data held", rx_data, held);
        get_rx(r);
        check(r == 16'h00C6, "R11", "word after hold", r, 16'h00C6);
        check(rx_valid == 1'b0, "R11", "valid cleared after ready", rx_valid, 0);

        // R7: role request while enabled is ignored, frame still runs as master
        set_cfg(1'b0, 9, 1'b0, 1'b0, 1'b1, 1'b0);
        slave_sel = 1'b1;
        tick();
        saw_cs = 1'b0;
        tx_data = 16'h0155; tx_valid = 1'b1;
        while (!tx_ready) tick();
        tick();
        tx_valid = 1'b0;
        repeat (3) begin
            if (!csn_o) saw_cs = 1'b1;
            tick();
        end
        check(saw_cs, "R7", "master frame after role request while enabled", saw_cs, 1);
        get_rx(r);
        check(r == 16'h0155, "R7", "master loopback word", r, 16'h0155);

        // Slave corners
        s_frame(7, 1'b0, 1'b0, 1'b1, 16'hF0A5, 16'h003C, 1'b0);
        s_frame(4, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0015, 1'b0);
        s_frame(11, 1'b0, 1'b1, 1'b1, 16'h0ABC, 16'h0F0F, 1'b1);

        // Random mix
        for (int k = 0; k < 30; k++)
            m_loop(3 + int'($urandom % 13), 1'($urandom), 1'($urandom), 16'($urandom));
        for (int k = 0; k < 20; k++)
            m_ext(3 + int'($urandom % 13), 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
        for (int k = 0; k < 8; k++)
            s_frame(3 + int'($urandom % 13), 1'($urandom), 1'($urandom), 1'($urandom),
                    16'($urandom), 16'($urandom), k == 5);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        summary();
        $finish;
    end

endmodule